// File: doc/BRIEF.md
# Memory-to-Memory Add Sequencer

This block carries out one compound command: it adds two words held in memory and writes the sum back over the first of them. The two addresses are not part of the command. Each one lives in a small pointer register file, and the command names the two registers by index. One start pulse launches a fixed micro-sequence on a single-port synchronous memory: a read through the first pointer into temporary A, a read through the second pointer into temporary B, an add that leaves the sum in A, and a store of A through the first pointer. A one-cycle done pulse closes the command.

The pointer registers are loaded through a separate write port, and the command never changes them. The same code can therefore be aimed at relocated data by rewriting one pointer. The memory accepts one access per cycle. Read data comes back on the cycle after the read is issued.

Top module: `mm_add_seq`

## Requirements
- R1: After reset, mem_rd, mem_wr and done are 0 and every pointer register holds 0.
- R2: A pointer write (reg_we=1) stores reg_wdata into register reg_widx. A command started on any later cycle uses the new value.
- R3: When start is seen while idle, the cycle after that edge issues a read (mem_rd=1, mem_wr=0) at the address held in register ptr_a_idx.
- R4: The second cycle of a command issues a read at the address held in register ptr_b_idx.
- R5: A command makes exactly two reads and one write. Cycles 3 and 4 have no access, and cycle 5 writes (mem_wr=1) to the first pointer's address.
- R6: The data written in cycle 5 is (word at first pointer + word at second pointer) modulo 2^DW. Each read word is taken from mem_rdata on the cycle after its read.
- R7: When both pointers hold the same address, through the same index or through two registers with equal contents, the stored value is twice the original word modulo 2^DW.
- R8: done is 1 in cycle 6 only. In cycle 7 the block is idle with done, mem_rd and mem_wr at 0.
- R9: A start seen during cycles 1 to 6 of a command is ignored and changes neither that command's accesses nor its data.
- R10: A command never changes any pointer register; later commands see the same addresses.
- R11: When a pointer write and an accepted start fall on the same cycle, the command uses the register's value from before that write.
- R12: mem_rd and mem_wr are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken only while idle |
| ptr_a_idx | input | IW | Index of the pointer register for the first operand and the result |
| ptr_b_idx | input | IW | Index of the pointer register for the second operand |
| reg_we | input | 1 | Pointer register write enable |
| reg_widx | input | IW | Pointer register index to write |
| reg_wdata | input | AW | Address value to write |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after mem_rd |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall on the same cycle: a pointer register write and the start of a command that reads that same register. The bench provokes this by driving reg_we at the first operand's index in the same cycle as start, with a new value. It then checks that the command's first read and its store both use the old address. It runs a second command to confirm that the new value took effect. Every index pair in the register file is swept against a bench memory model, and the expected sums are computed arithmetically. The sweep covers equal pointers, wrap-around values, and start held high during a running command.

// File: rtl/mm_add_pkg.sv
package mm_add_pkg;
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_RD_A,
        SEQ_RD_B,
        SEQ_WAIT_B,
        SEQ_ADD,
        SEQ_STORE,
        SEQ_DONE
    } seq_state_e;
endpackage

// File: rtl/mm_ptr_regfile.sv
module mm_ptr_regfile #(
    parameter int NREG = 8,
    parameter int AW   = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [AW-1:0] wdata,
    input  logic [IW-1:0] ridx_a,
    input  logic [IW-1:0] ridx_b,
    output logic [AW-1:0] rdata_a,
    output logic [AW-1:0] rdata_b
);
    logic [AW-1:0] regs_q [NREG];
    logic [AW-1:0] regs_d [NREG];

    // Next value per entry: write port wins over hold
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = (we && (widx == IW'(i))) ? wdata : regs_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    // Read ports show the registered value (pre-write in a write cycle)
    assign rdata_a = regs_q[ridx_a];
    assign rdata_b = regs_q[ridx_b];
endmodule

// File: rtl/mm_seq_ctrl.sv
module mm_seq_ctrl
    import mm_add_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] ptr_a,
    input  logic [AW-1:0] ptr_b,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          ld_a,
    output logic          ld_b,
    output logic          do_add,
    output logic          done,
    output logic          busy
);
    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] addr_a;
        logic [AW-1:0] addr_b;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    c_d.st     = SEQ_RD_A;
                    c_d.addr_a = ptr_a;
                    c_d.addr_b = ptr_b;
                end
            end
            SEQ_RD_A:   c_d.st = SEQ_RD_B;
            SEQ_RD_B:   c_d.st = SEQ_WAIT_B;
            SEQ_WAIT_B: c_d.st = SEQ_ADD;
            SEQ_ADD:    c_d.st = SEQ_STORE;
            SEQ_STORE:  c_d.st = SEQ_DONE;
            SEQ_DONE:   c_d.st = SEQ_IDLE;
            default:    c_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st     <= SEQ_IDLE;
            c_q.addr_a <= '0;
            c_q.addr_b <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    // Step decodes from the registered state
    assign mem_rd   = (c_q.st == SEQ_RD_A) || (c_q.st == SEQ_RD_B);
    assign mem_wr   = (c_q.st == SEQ_STORE);
    assign mem_addr = (c_q.st == SEQ_RD_B) ? c_q.addr_b : c_q.addr_a;
    assign ld_a     = (c_q.st == SEQ_RD_B);
    assign ld_b     = (c_q.st == SEQ_WAIT_B);
    assign do_add   = (c_q.st == SEQ_ADD);
    assign done     = (c_q.st == SEQ_DONE);
    assign busy     = (c_q.st != SEQ_IDLE);
endmodule

// File: rtl/mm_add_datapath.sv
module mm_add_datapath #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_a,
    input  logic          ld_b,
    input  logic          do_add,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] wdata
);
    typedef struct packed {
        logic [DW-1:0] tmp_a;
        logic [DW-1:0] tmp_b;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (ld_a)   dp_d.tmp_a = rdata;
        if (ld_b)   dp_d.tmp_b = rdata;
        if (do_add) dp_d.tmp_a = dp_q.tmp_a + dp_q.tmp_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q.tmp_a <= '0;
            dp_q.tmp_b <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign wdata = dp_q.tmp_a;
endmodule

// File: rtl/mm_add_seq.sv
module mm_add_seq #(
    parameter int NREG = 8,
    parameter int AW   = 16,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] ptr_a_idx,
    input  logic [IW-1:0] ptr_b_idx,
    input  logic          reg_we,
    input  logic [IW-1:0] reg_widx,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          done
);
    logic [AW-1:0] ptr_a_val;
    logic [AW-1:0] ptr_b_val;
    logic          ld_a;
    logic          ld_b;
    logic          do_add;
    logic          busy;

    mm_ptr_regfile #(.NREG(NREG), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .widx    (reg_widx),
        .wdata   (reg_wdata),
        .ridx_a  (ptr_a_idx),
        .ridx_b  (ptr_b_idx),
        .rdata_a (ptr_a_val),
        .rdata_b (ptr_b_val)
    );

    mm_seq_ctrl #(.AW(AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ptr_a    (ptr_a_val),
        .ptr_b    (ptr_b_val),
        .mem_addr (mem_addr),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .ld_a     (ld_a),
        .ld_b     (ld_b),
        .do_add   (do_add),
        .done     (done),
        .busy     (busy)
    );

    mm_add_datapath #(.DW(DW)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_a   (ld_a),
        .ld_b   (ld_b),
        .do_add (do_add),
        .rdata  (mem_rdata),
        .wdata  (mem_wdata)
    );
endmodule

// File: rtl/mm_add_seq_checker.sv
module mm_add_seq_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] ptr_a_val,
    input logic          done
);
    a_r3_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (mem_rd && !mem_wr && mem_addr == $past(ptr_a_val)));

    a_r4_two_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |=> !mem_rd);

    a_r5_store_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd, 4) && mem_addr == $past(mem_addr, 4)));

    a_r8_done_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (done && !mem_wr));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

bind mm_add_seq mm_add_seq_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .ptr_a_val (ptr_a_val),
    .done      (done)
);

// File: tb/mm_add_seq_test.sv
module mm_add_seq_test;
    localparam int NREG = 8;
    localparam int AW   = 16;
    localparam int DW   = 32;
    localparam int IW   = $clog2(NREG);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [IW-1:0] ptr_a_idx = '0;
    logic [IW-1:0] ptr_b_idx = '0;
    logic          reg_we = 1'b0;
    logic [IW-1:0] reg_widx = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic          mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [DW-1:0] mem [64];
    logic [AW-1:0] ptr_sh [NREG];

    always #10 clk = ~clk;

    mm_add_seq #(.NREG(NREG), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ptr_a_idx(ptr_a_idx), .ptr_b_idx(ptr_b_idx),
        .reg_we(reg_we), .reg_widx(reg_widx), .reg_wdata(reg_wdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
    );

    // Bench memory: one-cycle read latency
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_ptr(input int i, input logic [AW-1:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_widx = IW'(i); reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        ptr_sh[i] = v;
    endtask

    task automatic run_cmd(input int ia, input int ib, input bit hold,
                           input bit co_wr, input logic [AW-1:0] co_val);
        logic [AW-1:0] pa, pb;
        logic [DW-1:0] expv;
        pa = ptr_sh[ia];
        pb = ptr_sh[ib];
        expv = mem[pa[5:0]] + mem[pb[5:0]];
        @(negedge clk);
        start = 1'b1; ptr_a_idx = IW'(ia); ptr_b_idx = IW'(ib);
        if (co_wr) begin
            reg_we = 1'b1; reg_widx = IW'(ia); reg_wdata = co_val;
        end
        @(negedge clk); // cycle 1
        reg_we = 1'b0;
        if (!hold) start = 1'b0;
        else begin ptr_a_idx = IW'(ib); ptr_b_idx = IW'(ia); end
        chk(mem_rd && !mem_wr, "R3", "first read strobe", {mem_rd, mem_wr}, 2'b10);
        chk(mem_addr == pa, "R3 R10 R11", "first read addr", mem_addr, pa);
        @(negedge clk); // cycle 2
        chk(mem_rd && !mem_wr, "R4", "second read strobe", {mem_rd, mem_wr}, 2'b10);
        chk(mem_addr == pb, "R4 R10", "second read addr", mem_addr, pb);
        @(negedge clk); // cycle 3
        chk(!mem_rd && !mem_wr && !done, "R5 R9", "cycle 3 quiet", {mem_rd, mem_wr, done}, 0);
        @(negedge clk); // cycle 4
        chk(!mem_rd && !mem_wr && !done, "R5 R9", "cycle 4 quiet", {mem_rd, mem_wr, done}, 0);
        @(negedge clk); // cycle 5
        chk(mem_wr && !mem_rd && !done, "R5 R12", "store strobe", {mem_rd, mem_wr, done}, 3'b010);
        chk(mem_addr == pa, "R5 R11", "store addr", mem_addr, pa);
        chk(mem_wdata == expv, (pa == pb) ? "R7" : "R6", "store data", mem_wdata, expv);
        @(negedge clk); // cycle 6
        start = 1'b0;
        chk(done && !mem_rd && !mem_wr, "R8", "done pulse", {done, mem_rd, mem_wr}, 3'b100);
        @(negedge clk); // cycle 7
        chk(!done && !mem_rd && !mem_wr, "R8 R9", "idle after done", {done, mem_rd, mem_wr}, 0);
        chk(mem[pa[5:0]] == expv, "R6", "memory updated", mem[pa[5:0]], expv);
        if (co_wr) ptr_sh[ia] = co_val;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h9E37_79B9 * (i + 1) ^ 32'h0000_5A5A;
        for (int i = 0; i < NREG; i++) ptr_sh[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_rd && !mem_wr && !done, "R1", "reset outputs", {mem_rd, mem_wr, done}, 0);
        // R1: pointers are zero after reset, so both reads hit address 0
        run_cmd(0, 3, 1'b0, 1'b0, '0);

        // R2: load pointers; ptr5 aliases ptr0 for R7
        set_ptr(0, 16'd10); set_ptr(1, 16'd20); set_ptr(2, 16'd33); set_ptr(3, 16'd41);
        set_ptr(4, 16'd52); set_ptr(5, 16'd10); set_ptr(6, 16'd7);  set_ptr(7, 16'd63);

        // Wrap-around case R6
        mem[20] = 32'hFFFF_FFFF; mem[33] = 32'h0000_0001;
        run_cmd(1, 2, 1'b0, 1'b0, '0);
        chk(mem[20] == 32'h0, "R6", "wrap to zero", mem[20], 0);

        // Equal pointers via aliasing registers R7
        mem[10] = 32'h8000_0003;
        run_cmd(0, 5, 1'b0, 1'b0, '0);
        chk(mem[10] == 32'h0000_0006, "R7", "aliased double", mem[10], 32'h6);

        // Sweep over all index pairs; start held high on some (R9)
        for (int ia = 0; ia < NREG; ia++)
            for (int ib = 0; ib < NREG; ib++)
                run_cmd(ia, ib, ((ia + ib) % 3) == 0, 1'b0, '0);

        // R11: pointer write to the first operand's register in the start cycle
        run_cmd(3, 4, 1'b0, 1'b1, 16'd25);
        // R2: the new value applies to the next command
        run_cmd(3, 6, 1'b0, 1'b0, '0);
        chk(ptr_sh[3] == 16'd25, "R2", "pointer shadow", ptr_sh[3], 25);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule